// File: doc/BRIEF.md
# Serial Debug Line-State Controller

This block follows the condition of a single-wire serial debug data line. The line is sampled once per debug clock, and a separate strobe marks each cycle that carries a sample. The block counts unbroken runs of high samples and unbroken runs of low samples. From those runs it decides whether the port is in a line-reset condition, an idle condition, or active.

The block also screens the decoded transaction requests that arrive from a separate packet decoder. Each request names a port select bit, a read/write bit and a two-bit register address. After every line reset the port is locked. While it is locked, every request is refused with a FAULT acknowledge, with one exception. A read of the identification register is accepted once the line has passed through idle. That read returns a fixed 32-bit identification value and unlocks the port.

Packet bit decoding, parity, turnaround and the register file are handled elsewhere. This block only supplies the line state and an acknowledge code for each request.

Top module: `dbg_line_guard`

## Requirements
- R1: After synchronous reset `rst`, `state_o` is 2'b00 (line reset), `ack_vld_o` is 0 and the port is locked. The state encodings are line reset 2'b00, idle 2'b01 and active 2'b10.
- R2: When a strobed high sample is more than 50 consecutive strobed high samples in a row (that is, the 51st), `state_o` becomes 2'b00 at the same clock edge. After exactly 50 such samples the state is unchanged.
- R3: A strobed low sample ends a high run. The next high run counts again from one.
- R4: In line reset, the second consecutive strobed low sample moves `state_o` to idle (2'b01). A strobed high sample ends a low run, so low-high-low does not reach idle.
- R5: In idle, a strobed high sample that does not cause a line reset moves `state_o` to active (2'b10). In active, two consecutive strobed low samples return it to idle.
- R6: Cycles with `smp_en` low have no effect on the runs or on `state_o`, whatever `line_bit` holds.
- R7: Every request presented with `req_valid` is answered on the next cycle with `ack_vld_o`=1 and a one-hot `ack_o`, where OK=3'b001, WAIT=3'b010 and FAULT=3'b100. While the port is locked, any request other than the identification read gets FAULT.
- R8: The identification read is `req_ap`=0, `req_read`=1, `req_addr`=2'b00. If it arrives before the line has reached idle since the last line reset, it gets FAULT and the port stays locked.
- R9: An identification read after idle has been reached gets OK with `rdata_o`=32'h2BA01477, and it unlocks the port. After that, every request gets OK. `rdata_o` is zero on every other answer.
- R10: A write to the identification address (`req_ap`=0, `req_read`=0, `req_addr`=2'b00) targets the abort register. While locked it gets FAULT and does not unlock.
- R11: A new line reset locks the port again, even after the identification register has been read.
- R12: The high-run count saturates instead of wrapping. Over any unbroken high run, however long, `state_o` stays 2'b00 from the 51st sample onward, and two lows afterwards still lead to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| smp_en | input | 1 | Strobe: `line_bit` holds a valid line sample this cycle |
| line_bit | input | 1 | Sampled level of the debug data line |
| req_valid | input | 1 | A decoded request is presented this cycle |
| req_ap | input | 1 | 1 selects the access port, 0 selects the debug port |
| req_read | input | 1 | 1 for read, 0 for write |
| req_addr | input | 2 | Register address bits |
| state_o | output | 2 | Line state: 00 line reset, 01 idle, 10 active |
| ack_vld_o | output | 1 | An acknowledge is presented this cycle |
| ack_o | output | 3 | Acknowledge code, one-hot |
| rdata_o | output | 32 | Identification value on an accepted identification read, else zero |

## Verification
The line state changes at the same clock edge that takes the deciding sample, so `state_o` is due one edge after that sample is driven. An acknowledge and its `rdata_o` are registered, and they appear one edge after the request. The bench drives every input on the falling edge and compares all outputs on the next falling edge, against a cycle model kept in bench functions. This places each check exactly one rising edge after its stimulus. Directed runs hit the 50/51 boundary, the broken runs and the relock, and a seeded random phase with long biased runs covers the rest.

// File: rtl/dbg_line_pkg.sv
package dbg_line_pkg;
  typedef enum logic [1:0] {
    LS_RESET  = 2'b00,
    LS_IDLE   = 2'b01,
    LS_ACTIVE = 2'b10
  } line_st_t;

  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;

  localparam logic [31:0] ID_CONST = 32'h2BA0_1477;
endpackage

// File: rtl/dbg_run_ctr.sv
// Saturating counter of consecutive strobed samples that match a polarity.
module dbg_run_ctr #(
  parameter int SAT = 51,
  parameter int W   = $clog2(SAT + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         smp_en,
  input  logic         match,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] SAT_V = W'(SAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
    end else if (smp_en) begin
      if (!match)              cnt_o <= '0;
      else if (cnt_o != SAT_V) cnt_o <= cnt_o + 1'b1;
    end
  end

  // R3: an opposite sample restarts the run
  assert_run_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (smp_en && !match) |=> (cnt_o == '0));

  // R12: a full count is held, never wrapped
  assert_run_sat_R12: assert property (@(posedge clk) disable iff (rst)
    (smp_en && match && cnt_o == SAT_V) |=> (cnt_o == SAT_V));
endmodule

// File: rtl/dbg_line_fsm.sv
// Line condition tracker: reset / idle / active.
module dbg_line_fsm
  import dbg_line_pkg::*;
#(
  parameter int HI_LIMIT = 50,
  parameter int LO_NEED  = 2,
  parameter int HW       = $clog2(HI_LIMIT + 2),
  parameter int LW       = $clog2(LO_NEED + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_en,
  input  logic          line_bit,
  input  logic [HW-1:0] hi_cnt,
  input  logic [LW-1:0] lo_cnt,
  output line_st_t      state_o,
  output logic          seen_idle_o,
  output logic          reset_evt_o
);
  logic idle_evt;

  assign reset_evt_o = smp_en && line_bit  && (32'(hi_cnt) >= HI_LIMIT);
  assign idle_evt    = smp_en && !line_bit && (32'(lo_cnt) >= LO_NEED - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_o     <= LS_RESET;
      seen_idle_o <= 1'b0;
    end else if (reset_evt_o) begin
      state_o     <= LS_RESET;
      seen_idle_o <= 1'b0;
    end else if (smp_en) begin
      unique case (state_o)
        LS_RESET: if (idle_evt) begin
          state_o     <= LS_IDLE;
          seen_idle_o <= 1'b1;
        end
        LS_IDLE:   if (line_bit) state_o <= LS_ACTIVE;
        LS_ACTIVE: if (idle_evt) state_o <= LS_IDLE;
        default:   state_o <= LS_RESET;
      endcase
    end
  end

  // R2: a long high run forces line reset
  assert_long_high_R2: assert property (@(posedge clk) disable iff (rst)
    reset_evt_o |=> (state_o == LS_RESET));

  // R4: line reset is only left through a completed low run
  assert_idle_entry_R4: assert property (@(posedge clk) disable iff (rst)
    (state_o == LS_RESET && !idle_evt) |=> (state_o == LS_RESET));

  // R6: unstrobed cycles leave the state alone
  assert_no_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    !smp_en |=> $stable(state_o));
endmodule

// File: rtl/dbg_req_gate.sv
// Lock tracking and acknowledge generation for decoded requests.
module dbg_req_gate
  import dbg_line_pkg::*;
#(
  parameter int          AW       = 2,
  parameter logic [31:0] ID_VALUE = ID_CONST
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          relock,
  input  logic          seen_idle,
  input  logic          req_valid,
  input  logic          req_ap,
  input  logic          req_read,
  input  logic [AW-1:0] req_addr,
  output logic          ack_vld_o,
  output logic [2:0]    ack_o,
  output logic [31:0]   rdata_o
);
  logic locked;
  logic id_rd;
  logic grant;

  assign id_rd = req_valid && !req_ap && req_read && (req_addr == '0);
  assign grant = !locked || (id_rd && seen_idle);

  always_ff @(posedge clk) begin
    if (rst || relock)           locked <= 1'b1;
    else if (id_rd && seen_idle) locked <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_vld_o <= 1'b0;
      ack_o     <= '0;
      rdata_o   <= '0;
    end else begin
      ack_vld_o <= req_valid;
      ack_o     <= !req_valid ? 3'b000 : (grant ? ACK_OK : ACK_FAULT);
      rdata_o   <= (id_rd && grant) ? ID_VALUE : '0;
    end
  end

  // R7: locked port refuses everything but the identification read
  assert_fault_locked_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && locked && !id_rd) |=> (ack_vld_o && ack_o == ACK_FAULT));

  // R7: acknowledge code is one-hot when presented
  assert_ack_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    ack_vld_o |-> ($countones(ack_o) == 1));

  // R9: returned data is only ever the identification value with OK
  assert_id_value_R9: assert property (@(posedge clk) disable iff (rst)
    (ack_vld_o && rdata_o != '0) |-> (rdata_o == ID_VALUE && ack_o == ACK_OK));

  // R10: before idle is reached no request is granted
  assert_locked_pre_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && locked && !seen_idle) |=> (ack_o == ACK_FAULT));

  // R11: a line reset always re-locks
  assert_relock_R11: assert property (@(posedge clk) disable iff (rst)
    relock |=> locked);
endmodule

// File: rtl/dbg_line_guard.sv
module dbg_line_guard
  import dbg_line_pkg::*;
#(
  parameter int          HI_LIMIT = 50,
  parameter int          LO_NEED  = 2,
  parameter int          AW       = 2,
  parameter logic [31:0] ID_VALUE = ID_CONST
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_en,
  input  logic          line_bit,
  input  logic          req_valid,
  input  logic          req_ap,
  input  logic          req_read,
  input  logic [AW-1:0] req_addr,
  output logic [1:0]    state_o,
  output logic          ack_vld_o,
  output logic [2:0]    ack_o,
  output logic [31:0]   rdata_o
);
  localparam int HI_SAT = HI_LIMIT + 1;
  localparam int HW     = $clog2(HI_SAT + 1);
  localparam int LW     = $clog2(LO_NEED + 1);

  logic [HW-1:0] hi_cnt;
  logic [LW-1:0] lo_cnt;
  line_st_t      st;
  logic          seen_idle;
  logic          reset_evt;

  dbg_run_ctr #(.SAT(HI_SAT), .W(HW)) u_hi_run (
    .clk(clk), .rst(rst), .smp_en(smp_en), .match(line_bit), .cnt_o(hi_cnt)
  );

  dbg_run_ctr #(.SAT(LO_NEED), .W(LW)) u_lo_run (
    .clk(clk), .rst(rst), .smp_en(smp_en), .match(!line_bit), .cnt_o(lo_cnt)
  );

  dbg_line_fsm #(.HI_LIMIT(HI_LIMIT), .LO_NEED(LO_NEED), .HW(HW), .LW(LW)) u_fsm (
    .clk(clk), .rst(rst), .smp_en(smp_en), .line_bit(line_bit),
    .hi_cnt(hi_cnt), .lo_cnt(lo_cnt),
    .state_o(st), .seen_idle_o(seen_idle), .reset_evt_o(reset_evt)
  );

  dbg_req_gate #(.AW(AW), .ID_VALUE(ID_VALUE)) u_gate (
    .clk(clk), .rst(rst), .relock(reset_evt), .seen_idle(seen_idle),
    .req_valid(req_valid), .req_ap(req_ap), .req_read(req_read), .req_addr(req_addr),
    .ack_vld_o(ack_vld_o), .ack_o(ack_o), .rdata_o(rdata_o)
  );

  assign state_o = st;
endmodule

// File: tb/test_dbg_line_guard.sv
module test_dbg_line_guard;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_en = 1'b0, line_bit = 1'b0;
  logic        req_valid = 1'b0, req_ap = 1'b0, req_read = 1'b0;
  logic [1:0]  req_addr = 2'b00;
  logic [1:0]  state_o;
  logic        ack_vld_o;
  logic [2:0]  ack_o;
  logic [31:0] rdata_o;

  int n_run = 0, n_fail = 0;
  int m_hi, m_lo, m_st;
  bit m_lock, m_seen;

  localparam logic [31:0] ID = 32'h2BA01477;

  always #10 clk = ~clk;

  dbg_line_guard i_dbg_line_guard (
    .clk(clk), .rst(rst), .smp_en(smp_en), .line_bit(line_bit),
    .req_valid(req_valid), .req_ap(req_ap), .req_read(req_read), .req_addr(req_addr),
    .state_o(state_o), .ack_vld_o(ack_vld_o), .ack_o(ack_o), .rdata_o(rdata_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_ack(input bit rv, input bit grant);
    if (!rv) return 3'b000;
    return grant ? 3'b001 : 3'b100;
  endfunction

  task automatic model_reset();
    m_hi = 0; m_lo = 0; m_st = 0; m_lock = 1; m_seen = 0;
  endtask

  // One cycle: drive at falling edge, check against the model one rising edge later.
  task automatic cyc(input bit s, input bit b, input bit rv, input bit ap, input bit rd,
                     input logic [1:0] a, input string tag);
    bit idrd, grant, rev, iev;
    logic [2:0] e_ack;
    logic [31:0] e_rd;
    smp_en = s; line_bit = b; req_valid = rv; req_ap = ap; req_read = rd; req_addr = a;
    idrd  = rv && !ap && rd && (a == 2'b00);
    grant = !m_lock || (idrd && m_seen);
    e_ack = exp_ack(rv, grant);
    e_rd  = (rv && grant && idrd) ? ID : 32'h0;
    rev = s && b && (m_hi >= 50);
    iev = s && !b && (m_lo >= 1);
    if (rev) m_lock = 1;
    else if (idrd && m_seen) m_lock = 0;
    if (rev) begin
      m_st = 0; m_seen = 0;
    end else if (s) begin
      if (m_st == 0 && iev) begin m_st = 1; m_seen = 1; end
      else if (m_st == 1 && b) m_st = 2;
      else if (m_st == 2 && iev) m_st = 1;
    end
    if (s) begin
      if (b) begin m_lo = 0; if (m_hi < 51) m_hi++; end
      else   begin m_hi = 0; if (m_lo < 2) m_lo++; end
    end
    @(posedge clk);
    @(negedge clk);
    chk({tag, " state"}, 32'(state_o), 32'(m_st));
    chk({tag, " ack_vld"}, 32'(ack_vld_o), 32'(rv));
    chk({tag, " ack"}, 32'(ack_o), 32'(e_ack));
    chk({tag, " rdata"}, rdata_o, e_rd);
  endtask

  task automatic samp(input bit b, input string tag);
    cyc(1'b1, b, 1'b0, 1'b0, 1'b0, 2'b00, tag);
  endtask

  task automatic req(input bit ap, input bit rd, input logic [1:0] a, input string tag);
    cyc(1'b0, 1'b0, 1'b1, ap, rd, a, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int run_left;
    bit cur;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 state after reset", 32'(state_o), 32'h0);
    chk("R1 ack_vld after reset", 32'(ack_vld_o), 32'h0);

    // R10 abort write locked, R8 early id read, R7 AP read
    req(1'b0, 1'b0, 2'b00, "R10 abort write");
    chk("R10 fault", 32'(ack_o), 32'h4);
    req(1'b0, 1'b1, 2'b00, "R8 id read before idle");
    chk("R8 fault", 32'(ack_o), 32'h4);
    req(1'b1, 1'b1, 2'b01, "R7 ap read locked");
    chk("R7 fault", 32'(ack_o), 32'h4);

    // R4 broken low run, then completed
    samp(1'b0, "R4 low1");
    samp(1'b1, "R4 high");
    samp(1'b0, "R4 low again");
    chk("R4 still reset", 32'(state_o), 32'h0);
    samp(1'b0, "R4 second low");
    chk("R4 idle", 32'(state_o), 32'h1);

    // R5 idle <-> active
    samp(1'b1, "R5 high");
    chk("R5 active", 32'(state_o), 32'h2);
    samp(1'b0, "R5 low1");
    samp(1'b0, "R5 low2");
    chk("R5 back idle", 32'(state_o), 32'h1);

    // R6 unstrobed high does nothing
    for (int i = 0; i < 60; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, "R6 unstrobed");
    chk("R6 idle kept", 32'(state_o), 32'h1);

    // R9 unlock
    req(1'b0, 1'b1, 2'b00, "R9 id read");
    chk("R9 ok", 32'(ack_o), 32'h1);
    chk("R9 id value", rdata_o, ID);
    req(1'b1, 1'b0, 2'b10, "R9 ap write after unlock");
    chk("R9 ok after unlock", 32'(ack_o), 32'h1);
    req(1'b0, 1'b0, 2'b00, "R10 abort write unlocked");
    chk("R10 ok unlocked", 32'(ack_o), 32'h1);

    // R2 / R3 boundary
    for (int i = 0; i < 50; i++) samp(1'b1, "R2 high run");
    chk("R2 50 highs no reset", 32'(state_o), 32'h2);
    samp(1'b0, "R3 break");
    for (int i = 0; i < 50; i++) samp(1'b1, "R3 high run");
    chk("R3 run restarted", 32'(state_o), 32'h2);
    samp(1'b1, "R2 51st high");
    chk("R2 reset at 51", 32'(state_o), 32'h0);

    // R11 relock
    req(1'b1, 1'b1, 2'b00, "R11 ap read relocked");
    chk("R11 fault", 32'(ack_o), 32'h4);

    // R12 very long high run
    for (int i = 0; i < 300; i++) samp(1'b1, "R12 long high");
    chk("R12 still reset", 32'(state_o), 32'h0);
    samp(1'b0, "R12 low1");
    samp(1'b0, "R12 low2");
    chk("R12 idle after long high", 32'(state_o), 32'h1);
    req(1'b0, 1'b1, 2'b00, "R12 id read");
    chk("R12 ok", 32'(ack_o), 32'h1);

    // Random phase (R2 R4 R5 R7 R9 R11) with biased runs
    void'($urandom(32'd1234));
    run_left = 0; cur = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      bit s, rv, ap, rd;
      logic [1:0] a;
      if (run_left == 0) begin
        cur = $urandom_range(1, 0) != 0;
        run_left = ($urandom_range(3, 0) == 0) ? $urandom_range(70, 40) : $urandom_range(4, 1);
      end
      s  = $urandom_range(7, 0) != 0;
      if (s) run_left--;
      rv = $urandom_range(3, 0) == 0;
      ap = $urandom_range(1, 0) != 0 && $urandom_range(1, 0) != 0;
      rd = $urandom_range(1, 0) != 0;
      a  = ($urandom_range(1, 0) != 0) ? 2'b00 : 2'($urandom_range(3, 0));
      cyc(s, cur, rv, ap, rd, a, "random R2 R5 R7 R9");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule